// File: doc/BRIEF.md
# Single-Bus Processor Core with Fetch/Execute Sequencer

A compact processor core in which every data movement uses one shared internal bus. Four general registers, the program counter, the instruction register, the memory address and data registers, and two hidden staging registers (an operand latch and a result latch) all sit on that bus. A control sequencer steps through the fetch phase and then the execute phase of each instruction, with one bus transfer per cycle. The core reaches external memory only through its address and data registers, using a request/ready handshake.

Each instruction word holds a 4-bit opcode in bits [15:12], a destination register number in bits [11:10], a source register number in bits [9:8] and an 8-bit address or target in bits [7:0]. Opcodes: 0 no-op, 1 copy register, 2 add, 3 subtract, 4 bitwise AND, 5 bitwise OR, 6 load from address, 7 store to address, 8 jump, 9 load the immediate held in the following word. Opcodes 10 to 15 are unassigned.

Top module: `sbc_core`

## Requirements
- R1: Synchronous reset clears the program counter, the instruction register and all four general registers to zero, holds `mem_rd` and `mem_wr` low, and the first memory transaction after reset is an instruction read at address 0.
- R2: Every instruction starts with a read at the program counter into the instruction register, after which the counter advances by one, so that without a jump successive fetches use consecutive addresses.
- R3: Opcode 1 copies the register named in bits [9:8] into the register named in bits [11:10].
- R4: Opcodes 2, 3, 4 and 5 replace the destination register with destination plus, minus, AND, OR source, modulo 2^16.
- R5: With a zero-wait memory, an arithmetic or logic instruction takes 8 clock cycles from its own fetch request to the next fetch request (4 fetch cycles and 4 execute cycles).
- R6: Opcode 6 reads memory at the 8-bit address field and writes the returned word into the destination register.
- R7: Opcode 7 writes the source register to memory at the address field, with `mem_wdata` valid for as long as `mem_wr` is high.
- R8: Opcode 8 loads the address field into the program counter, so the next fetch is at that address.
- R9: Opcode 9 reads the word after the instruction, places it in the destination register, and resumes fetching two words after the instruction.
- R10: A request (`mem_rd` or `mem_wr`) stays high with a stable address and write data until the cycle in which `mem_ready` is high, drops in the next cycle, and the two requests are never high together.
- R11: At most one source drives the internal bus in any cycle.
- R12: Unassigned opcodes and opcode 0 change no register and write no memory; the next fetch is at the following address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Memory address, from the address register |
| mem_rd | output | 1 | Read request, held until ready |
| mem_wr | output | 1 | Write request, held until ready |
| mem_wdata | output | DATA_W | Write data, from the data register |
| mem_rdata | input | DATA_W | Read data, valid while `mem_ready` is high |
| mem_ready | input | 1 | Memory completes the pending request this cycle |

## Verification
The bench uses the default parameters: a 16-bit word, an 8-bit address space and four general registers, so that every opcode and every register field fits the word. It runs the same program twice, once with a memory that answers at once and once with two wait cycles per access. The zero-wait run fixes the cycle count of an arithmetic instruction. The delayed run holds each request across several cycles, which exposes any loss of address or write data while the core waits for ready.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_MOV = 4'd1;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'd2;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'd3;
  localparam logic [OPC_W-1:0] OPC_AND = 4'd4;
  localparam logic [OPC_W-1:0] OPC_OR  = 4'd5;
  localparam logic [OPC_W-1:0] OPC_LD  = 4'd6;
  localparam logic [OPC_W-1:0] OPC_ST  = 4'd7;
  localparam logic [OPC_W-1:0] OPC_JMP = 4'd8;
  localparam logic [OPC_W-1:0] OPC_LDI = 4'd9;

  // bus source slots; general registers follow SRC_REG0
  localparam int SRC_PC   = 0;
  localparam int SRC_MDR  = 1;
  localparam int SRC_Z    = 2;
  localparam int SRC_IR   = 3;
  localparam int SRC_REG0 = 4;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;

  typedef enum logic [4:0] {
    ST_F_ADDR, ST_F_WAIT, ST_F_IR, ST_F_PC,
    ST_MOV,
    ST_A_Y, ST_A_OP, ST_A_Z, ST_A_WB,
    ST_LD_ADDR, ST_LD_WAIT, ST_LD_WB,
    ST_S_ADDR, ST_S_DATA, ST_S_WAIT,
    ST_JMP,
    ST_X_ADDR, ST_X_WAIT, ST_X_PC, ST_X_WB
  } seq_state_e;

endpackage

// File: rtl/sbc_regs.sv
module sbc_regs #(
  parameter int DATA_W = 16,
  parameter int NREG   = 4,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [REG_W-1:0]             widx,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NREG-1:0][DATA_W-1:0]  q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        q[i] <= '0;
      else if (we && widx == REG_W'(i))
        q[i] <= wdata;
    end
  end
endmodule

// File: rtl/sbc_alu.sv
module sbc_alu
  import sbc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus,
  input  logic              y_ld,
  input  logic              res_ld,
  input  logic              z_ld,
  input  logic              z_inc,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] z
);
  logic [DATA_W-1:0] y_q, res_q, comb_res;

  always_comb begin
    unique case (op)
      ALU_ADD: comb_res = y_q + bus;
      ALU_SUB: comb_res = y_q - bus;
      ALU_AND: comb_res = y_q & bus;
      default: comb_res = y_q | bus;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q   <= '0;
      res_q <= '0;
      z     <= '0;
    end else begin
      if (y_ld)   y_q   <= bus;
      if (res_ld) res_q <= comb_res;
      if (z_inc)      z <= bus + 1'b1;
      else if (z_ld)  z <= res_q;
    end
  end
endmodule

// File: rtl/sbc_seq.sv
module sbc_seq
  import sbc_pkg::*;
#(
  parameter int NREG   = 4,
  localparam int REG_W = $clog2(NREG),
  localparam int NSRC  = SRC_REG0 + NREG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opc,
  input  logic [REG_W-1:0] f_rd,
  input  logic [REG_W-1:0] f_rs,
  input  logic             mem_ready,
  output logic [NSRC-1:0]  bus_src,
  output logic             pc_ld,
  output logic             ir_ld,
  output logic             mar_ld,
  output logic             mdr_ld_bus,
  output logic             mdr_ld_mem,
  output logic             y_ld,
  output logic             res_ld,
  output logic             z_ld,
  output logic             z_inc,
  output logic             reg_ld,
  output logic [REG_W-1:0] reg_idx,
  output alu_op_e          alu_op,
  output logic             mem_rd,
  output logic             mem_wr
);
  seq_state_e state_q, state_d;

  function automatic logic [NSRC-1:0] one_src(input int slot);
    return NSRC'(1) << slot;
  endfunction

  function automatic logic [NSRC-1:0] reg_src(input logic [REG_W-1:0] r);
    return NSRC'(1) << (SRC_REG0 + int'(r));
  endfunction

  always_comb begin
    unique case (opc)
      OPC_SUB: alu_op = ALU_SUB;
      OPC_AND: alu_op = ALU_AND;
      OPC_OR:  alu_op = ALU_OR;
      default: alu_op = ALU_ADD;
    endcase
  end

  always_comb begin
    state_d    = state_q;
    bus_src    = '0;
    pc_ld      = 1'b0;
    ir_ld      = 1'b0;
    mar_ld     = 1'b0;
    mdr_ld_bus = 1'b0;
    mdr_ld_mem = 1'b0;
    y_ld       = 1'b0;
    res_ld     = 1'b0;
    z_ld       = 1'b0;
    z_inc      = 1'b0;
    reg_ld     = 1'b0;
    reg_idx    = f_rd;
    unique case (state_q)
      ST_F_ADDR: begin
        bus_src = one_src(SRC_PC); mar_ld = 1'b1; z_inc = 1'b1;
        state_d = ST_F_WAIT;
      end
      ST_F_WAIT: if (mem_ready) begin
        mdr_ld_mem = 1'b1; state_d = ST_F_IR;
      end
      ST_F_IR: begin
        bus_src = one_src(SRC_MDR); ir_ld = 1'b1; state_d = ST_F_PC;
      end
      ST_F_PC: begin
        bus_src = one_src(SRC_Z); pc_ld = 1'b1;
        unique case (opc)
          OPC_MOV:                          state_d = ST_MOV;
          OPC_ADD, OPC_SUB, OPC_AND, OPC_OR: state_d = ST_A_Y;
          OPC_LD:                           state_d = ST_LD_ADDR;
          OPC_ST:                           state_d = ST_S_ADDR;
          OPC_JMP:                          state_d = ST_JMP;
          OPC_LDI:                          state_d = ST_X_ADDR;
          default:                          state_d = ST_F_ADDR;
        endcase
      end
      ST_MOV: begin
        bus_src = reg_src(f_rs); reg_ld = 1'b1; state_d = ST_F_ADDR;
      end
      ST_A_Y:  begin bus_src = reg_src(f_rd); y_ld = 1'b1; state_d = ST_A_OP; end
      ST_A_OP: begin bus_src = reg_src(f_rs); res_ld = 1'b1; state_d = ST_A_Z; end
      ST_A_Z:  begin z_ld = 1'b1; state_d = ST_A_WB; end
      ST_A_WB: begin
        bus_src = one_src(SRC_Z); reg_ld = 1'b1; state_d = ST_F_ADDR;
      end
      ST_LD_ADDR: begin
        bus_src = one_src(SRC_IR); mar_ld = 1'b1; state_d = ST_LD_WAIT;
      end
      ST_LD_WAIT: if (mem_ready) begin
        mdr_ld_mem = 1'b1; state_d = ST_LD_WB;
      end
      ST_LD_WB: begin
        bus_src = one_src(SRC_MDR); reg_ld = 1'b1; state_d = ST_F_ADDR;
      end
      ST_S_ADDR: begin
        bus_src = one_src(SRC_IR); mar_ld = 1'b1; state_d = ST_S_DATA;
      end
      ST_S_DATA: begin
        bus_src = reg_src(f_rs); mdr_ld_bus = 1'b1; state_d = ST_S_WAIT;
      end
      ST_S_WAIT: if (mem_ready) state_d = ST_F_ADDR;
      ST_JMP: begin
        bus_src = one_src(SRC_IR); pc_ld = 1'b1; state_d = ST_F_ADDR;
      end
      ST_X_ADDR: begin
        bus_src = one_src(SRC_PC); mar_ld = 1'b1; z_inc = 1'b1;
        state_d = ST_X_WAIT;
      end
      ST_X_WAIT: if (mem_ready) begin
        mdr_ld_mem = 1'b1; state_d = ST_X_PC;
      end
      ST_X_PC: begin
        bus_src = one_src(SRC_Z); pc_ld = 1'b1; state_d = ST_X_WB;
      end
      ST_X_WB: begin
        bus_src = one_src(SRC_MDR); reg_ld = 1'b1; state_d = ST_F_ADDR;
      end
      default: state_d = ST_F_ADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_F_ADDR;
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_F_ADDR || state_q == ST_LD_ADDR || state_q == ST_X_ADDR)
        mem_rd <= 1'b1;
      else if (mdr_ld_mem)
        mem_rd <= 1'b0;
      if (state_q == ST_S_DATA)
        mem_wr <= 1'b1;
      else if (state_q == ST_S_WAIT && mem_ready)
        mem_wr <= 1'b0;
    end
  end
endmodule

// File: rtl/sbc_core.sv
module sbc_core
  import sbc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int NREG   = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  localparam int REG_W   = $clog2(NREG);
  localparam int NSRC    = SRC_REG0 + NREG;
  localparam int RD_MSB  = DATA_W - OPC_W - 1;
  localparam int RS_MSB  = RD_MSB - REG_W;

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ir_q, mdr_q, bus, z;
  logic [NSRC-1:0]   bus_src;
  logic [DATA_W-1:0] src_val [NSRC];
  logic [NREG-1:0][DATA_W-1:0] gpr;
  logic pc_ld, ir_ld, mar_ld, mdr_ld_bus, mdr_ld_mem;
  logic y_ld, res_ld, z_ld, z_inc, reg_ld;
  logic [REG_W-1:0] reg_idx;
  alu_op_e alu_op;

  assign src_val[SRC_PC]  = {{(DATA_W-ADDR_W){1'b0}}, pc_q};
  assign src_val[SRC_MDR] = mdr_q;
  assign src_val[SRC_Z]   = z;
  assign src_val[SRC_IR]  = {{(DATA_W-ADDR_W){1'b0}}, ir_q[ADDR_W-1:0]};
  for (genvar i = 0; i < NREG; i++) begin : g_src
    assign src_val[SRC_REG0+i] = gpr[i];
  end

  // single shared bus: AND-OR of the selected source
  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++)
      bus = bus | (src_val[i] & {DATA_W{bus_src[i]}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
    end else begin
      if (pc_ld)  pc_q  <= bus[ADDR_W-1:0];
      if (ir_ld)  ir_q  <= bus;
      if (mar_ld) mar_q <= bus[ADDR_W-1:0];
      if (mdr_ld_mem)      mdr_q <= mem_rdata;
      else if (mdr_ld_bus) mdr_q <= bus;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;

  sbc_seq #(.NREG(NREG)) u_seq (
    .clk(clk), .rst(rst),
    .opc(ir_q[DATA_W-1 -: OPC_W]),
    .f_rd(ir_q[RD_MSB -: REG_W]),
    .f_rs(ir_q[RS_MSB -: REG_W]),
    .mem_ready(mem_ready),
    .bus_src(bus_src), .pc_ld(pc_ld), .ir_ld(ir_ld), .mar_ld(mar_ld),
    .mdr_ld_bus(mdr_ld_bus), .mdr_ld_mem(mdr_ld_mem),
    .y_ld(y_ld), .res_ld(res_ld), .z_ld(z_ld), .z_inc(z_inc),
    .reg_ld(reg_ld), .reg_idx(reg_idx), .alu_op(alu_op),
    .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  sbc_alu #(.DATA_W(DATA_W)) u_alu (
    .clk(clk), .rst(rst), .bus(bus), .y_ld(y_ld), .res_ld(res_ld),
    .z_ld(z_ld), .z_inc(z_inc), .op(alu_op), .z(z)
  );

  sbc_regs #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
    .clk(clk), .rst(rst), .we(reg_ld), .widx(reg_idx), .wdata(bus), .q(gpr)
  );
endmodule

// File: rtl/sbc_core_chk.sv
module sbc_core_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int NSRC   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   bus_src,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] ir_q
);
  logic prev_rst_q;

  always_ff @(posedge clk) prev_rst_q <= rst;

  always @(posedge clk) begin
    if (prev_rst_q)
      assert_reset_state_R1: assert (pc_q == '0 && ir_q == '0 && !mem_rd && !mem_wr)
        else $error("reset state wrong");
  end

  assert_one_driver_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_src));

  assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  assert_req_drop_R10: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && mem_ready) |=> !(mem_rd || mem_wr));
endmodule

bind sbc_core sbc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .bus_src(bus_src), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .pc_q(pc_q), .ir_q(ir_q)
);

// File: tb/sbc_core_tb.sv
module sbc_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int MSZ = 1 << AW;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, mem_ready;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbc_core #(.DATA_W(DW), .ADDR_W(AW), .NREG(4)) u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  typedef struct {
    bit    wr;
    int    addr;
    int    data;
    int    kind;   // 0 data access, 1 fetch, 2 fetch of an ALU instruction
    string req;
  } xact_t;

  logic [DW-1:0] mem [MSZ];
  logic [DW-1:0] mm  [MSZ];
  string         tagm [MSZ];
  xact_t expq[$];

  int checks = 0, fails = 0;
  int cyc = 0, rst_edges = 0;
  int lat = 0, wait_cnt = 0, alu_cyc = -1;
  bit pend_prev = 0, prev_rd = 0;
  int prev_addr = 0, prev_wdata = 0;
  int wp = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) rst_edges++; else rst_edges = 0;
  end

  task automatic complete();
    xact_t e;
    if (expq.size() == 0) return;
    e = expq.pop_front();
    check(e.wr == mem_wr, e.req, "access kind", int'(mem_wr), int'(e.wr));
    check(int'(mem_addr) == e.addr, e.req, "address", int'(mem_addr), e.addr);
    if (e.wr)
      check(int'(mem_wdata) == e.data, e.req, "write data", int'(mem_wdata), e.data);
    if (e.kind != 0) begin
      if (lat == 0 && alu_cyc >= 0)
        check(cyc - alu_cyc == 8, "R5", "fetch-to-fetch cycles", cyc - alu_cyc, 8);
      alu_cyc = (e.kind == 2) ? cyc : -1;
    end
  endtask

  // memory responder and handshake monitor, away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      mem_ready = 1'b0;
      wait_cnt = 0;
      pend_prev = 0;
      if (rst_edges >= 1) begin
        check(!mem_rd && !mem_wr, "R1", "requests during reset",
              int'({mem_rd, mem_wr}), 0);
      end
    end else if (mem_ready) begin
      mem_ready = 1'b0;
      wait_cnt = 0;
      pend_prev = 0;
    end else if (mem_rd || mem_wr) begin
      if (pend_prev) begin
        // R10: pending request held steady while not ready
        check(mem_rd == prev_rd && int'(mem_addr) == prev_addr &&
              (prev_rd || int'(mem_wdata) == prev_wdata),
              "R10", "held request", int'(mem_addr), prev_addr);
      end
      check(!(mem_rd && mem_wr), "R10", "both requests", 1, 0);
      if (wait_cnt == lat) begin
        mem_ready = 1'b1;
        mem_rdata = mem_rd ? mem[mem_addr] : '0;
        if (mem_wr) mem[mem_addr] = mem_wdata;
        complete();
        pend_prev = 0;
      end else begin
        wait_cnt++;
        pend_prev = 1;
        prev_rd = mem_rd;
        prev_addr = int'(mem_addr);
        prev_wdata = int'(mem_wdata);
      end
    end else begin
      pend_prev = 0;
    end
  end

  function automatic logic [DW-1:0] enc(input int op, input int rd,
                                        input int rs, input int a);
    return DW'((op << 12) | (rd << 10) | (rs << 8) | (a & 8'hFF));
  endfunction

  task automatic emit(input logic [DW-1:0] w, input string tag);
    mem[wp] = w;
    tagm[wp] = tag;
    wp++;
  endtask

  task automatic load_program();
    for (int i = 0; i < MSZ; i++) begin
      mem[i] = '0;
      tagm[i] = "R2";
    end
    wp = 0;
    emit(enc(7, 0, 3, 8'h90), "R1");       // store R3, zero after reset
    emit(enc(9, 0, 0, 0), "R9");           // R0 <- 0x1234
    emit(16'h1234, "R9");
    emit(enc(9, 1, 0, 0), "R9");           // R1 <- 0x0F0F
    emit(16'h0F0F, "R9");
    emit(enc(2, 0, 1, 0), "R4");           // R0 = 0x2143
    emit(enc(7, 0, 0, 8'h91), "R4");
    emit(enc(9, 2, 0, 0), "R9");           // R2 <- 0xFFFF
    emit(16'hFFFF, "R9");
    emit(enc(9, 3, 0, 0), "R9");           // R3 <- 0x0001
    emit(16'h0001, "R9");
    emit(enc(7, 0, 2, 8'h9A), "R9");
    emit(enc(2, 2, 3, 0), "R4");           // add wraps to 0
    emit(enc(7, 0, 2, 8'h92), "R4");
    emit(enc(3, 2, 3, 0), "R4");           // 0 - 1 wraps to 0xFFFF
    emit(enc(7, 0, 2, 8'h93), "R4");
    emit(enc(4, 0, 1, 0), "R4");           // 0x2143 & 0x0F0F
    emit(enc(7, 0, 0, 8'h94), "R4");
    emit(enc(5, 0, 2, 0), "R4");           // OR with 0xFFFF
    emit(enc(7, 0, 0, 8'h95), "R4");
    emit(enc(1, 1, 3, 0), "R3");           // R1 <- R3
    emit(enc(7, 0, 1, 8'h96), "R3");
    emit(enc(15, 1, 2, 8'h96), "R12");     // unassigned opcode
    emit(enc(0, 2, 1, 8'h97), "R12");      // no-op
    emit(enc(7, 0, 1, 8'h97), "R12");
    emit(enc(7, 0, 2, 8'h9B), "R12");
    emit(enc(6, 2, 0, 8'hA0), "R6");       // R2 <- mem[0xA0]
    emit(enc(7, 0, 2, 8'h98), "R6");
    emit(enc(8, 0, 0, 8'h40), "R8");
    mem[8'hA0] = 16'hBEEF;
    mem[8'h40] = enc(7, 0, 0, 8'h99);  tagm[8'h40] = "R8";
    mem[8'h41] = enc(8, 0, 0, 8'h40);  tagm[8'h41] = "R8";
    for (int i = 0; i < MSZ; i++) mm[i] = mem[i];
  endtask

  // behavioural instruction-level model producing the expected transactions
  task automatic run_model(input int steps);
    int r [4];
    int pc, op, rd, rs, a;
    logic [DW-1:0] w;
    xact_t e;
    string ftag;
    for (int i = 0; i < 4; i++) r[i] = 0;
    pc = 0;
    ftag = "R1";
    for (int s = 0; s < steps; s++) begin
      w = mm[pc];
      op = int'(w[15:12]); rd = int'(w[11:10]); rs = int'(w[9:8]); a = int'(w[7:0]);
      e.wr = 0; e.addr = pc; e.data = int'(w);
      e.kind = (op >= 2 && op <= 5) ? 2 : 1;
      e.req = ftag;
      expq.push_back(e);
      ftag = "R2";
      pc = (pc + 1) % MSZ;
      case (op)
        1: r[rd] = r[rs];
        2: r[rd] = (r[rd] + r[rs]) & 16'hFFFF;
        3: r[rd] = (r[rd] - r[rs]) & 16'hFFFF;
        4: r[rd] = r[rd] & r[rs];
        5: r[rd] = r[rd] | r[rs];
        6: begin
          e.wr = 0; e.addr = a; e.data = int'(mm[a]); e.kind = 0; e.req = "R6";
          expq.push_back(e);
          r[rd] = int'(mm[a]);
        end
        7: begin
          e.wr = 1; e.addr = a; e.data = r[rs]; e.kind = 0; e.req = tagm[(pc + MSZ - 1) % MSZ];
          expq.push_back(e);
          mm[a] = DW'(r[rs]);
        end
        8: begin pc = a; ftag = "R8"; end
        9: begin
          e.wr = 0; e.addr = pc; e.data = int'(mm[pc]); e.kind = 0; e.req = "R9";
          expq.push_back(e);
          r[rd] = int'(mm[pc]);
          pc = (pc + 1) % MSZ;
          ftag = "R9";
        end
        default: ftag = "R12";
      endcase
    end
  endtask

  task automatic run_program(input int latency);
    @(negedge clk);
    rst = 1'b1;
    load_program();
    expq.delete();
    run_model(40);
    lat = latency;
    alu_cyc = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    while (expq.size() > 0) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    mem_ready = 1'b0;
    mem_rdata = '0;
    run_program(0);
    run_program(2);
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
    summary();
    $finish;
  end
endmodule